// File: doc/BRIEF.md
# GF(4096) Composite-Field Multiplier

This block multiplies two 12-bit elements of GF(2^12) for a Reed-Solomon codec whose symbols are 12 bits wide. The field is not reduced by one degree-12 polynomial. It is built as a quadratic extension over GF(64), the field of 6-bit values reduced modulo x^6 + x + 1. An element is a pair {hi, lo}, which stands for hi·X + lo, with X^2 = X + k and k = 0x21. Each product uses three subfield multiplies: the cross term, the low-by-low term and the high-by-high term. One constant multiply by k then folds the high-by-high term into the low half.

A step mode supports building the codec's table of powers. In this mode the second operand is ignored and the first operand is multiplied by the fixed element 0xE01. A zero input gives 1, so the table can start from zero. A parameter selects whether the result is registered with a valid strobe, or whether the block stays purely combinational.

Top module: `gf4096_tower_mul`

## Requirements
- R1: Subfield products are reduced modulo x^6 + x + 1. For operands whose high halves (bits 11:6) are zero, the result is {6'b0, lo_a·lo_b}. For example, 0x020 × 0x002 gives 0x003.
- R2: Outside step mode, the result's bits 11:6 equal (ah^al)·(bh^bl) ^ al·bl. Its bits 5:0 equal (ah·bh)·0x21 ^ al·bl. Every product (·) here is a GF(64) product.
- R3: The element 0x001 is the multiplicative identity: a × 1 = a and 1 × b = b.
- R4: The product is commutative: a × b = b × a.
- R5: Outside step mode, a zero operand gives a zero result.
- R6: When step_mode = 1 and op_a ≠ 0, the result is op_a × 0xE01, and op_b has no effect.
- R7: When step_mode = 1 and op_a = 0, the result is 0x001.
- R8: With OUT_REG = 1, out_valid is asserted in the cycle after each cycle in which in_valid is high. The product for that input is present in the same cycle.
- R9: With OUT_REG = 1, a cycle with in_valid low gives out_valid low in the next cycle. The product keeps its previous value, whatever the operands do.
- R10: After reset, out_valid is 0 and product is 0x000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output stage |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operands are valid this cycle |
| step_mode | input | 1 | 1: multiply op_a by the power-step constant |
| op_a | input | 12 | First operand {hi, lo} |
| op_b | input | 12 | Second operand, unused in step mode |
| out_valid | output | 1 | Product is valid |
| product | output | 12 | Field product |

## Verification
The corner that is hardest to reach from the ports is the step-mode zero override. It only matters when op_a is exactly zero, and random operands almost never produce that. The stimulus therefore applies a zero operand in step mode with a non-zero op_b in the same transaction, so the override is the only way to get 1. The subfield reduction path is reached separately, with low-half-only operands whose product overflows into bit 6. The bench's own reference applies the quadratic extension in schoolbook form over a carry-less product that is reduced bit by bit.

// File: rtl/gf_tower_pkg.sv
package gf_tower_pkg;
  localparam int          GFT_SUB_W    = 6;
  localparam logic [6:0]  GFT_SUB_POLY = 7'h43;
  localparam logic [5:0]  GFT_EXT_K    = 6'h21;
  localparam logic [11:0] GFT_STEP_K   = 12'hE01;
endpackage

// File: rtl/gf_sub_mul.sv
module gf_sub_mul #(
  parameter int             SUB_W    = 6,
  parameter logic [SUB_W:0] SUB_POLY = 7'h43
) (
  input  logic [SUB_W-1:0] x,
  input  logic [SUB_W-1:0] y,
  output logic [SUB_W-1:0] p
);
  function automatic logic [SUB_W-1:0] shift_add_mul(input logic [SUB_W-1:0] u,
                                                     input logic [SUB_W-1:0] v);
    logic [SUB_W-1:0] acc;
    logic [SUB_W-1:0] us;
    logic [SUB_W:0]   vs;
    acc = '0;
    us  = u;
    vs  = {1'b0, v};
    for (int i = 0; i < SUB_W; i++) begin
      if (us[0]) acc = acc ^ vs[SUB_W-1:0];
      us = us >> 1;
      vs = vs << 1;
      if (vs[SUB_W]) vs = vs ^ SUB_POLY;
    end
    return acc;
  endfunction

  assign p = shift_add_mul(x, y);

  always_comb begin
    // R3
    if (x == SUB_W'(1)) begin
      sub_identity_chk: assert (p == y);
    end
  end
endmodule

// File: rtl/gf_tower_core.sv
module gf_tower_core #(
  parameter int             SUB_W    = 6,
  parameter logic [SUB_W:0] SUB_POLY = 7'h43,
  parameter logic [SUB_W-1:0] EXT_K  = 6'h21,
  localparam int            EL_W     = 2 * SUB_W
) (
  input  logic [EL_W-1:0] a,
  input  logic [EL_W-1:0] b,
  output logic [EL_W-1:0] p
);
  logic [SUB_W-1:0] a_hi, a_lo, b_hi, b_lo;
  logic [SUB_W-1:0] sum_a, sum_b;
  logic [SUB_W-1:0] t_cross, t_low, t_high, t_high_k;
  logic [SUB_W-1:0] hi_out, lo_out;

  assign {a_hi, a_lo} = a;
  assign {b_hi, b_lo} = b;
  assign sum_a = a_hi ^ a_lo;
  assign sum_b = b_hi ^ b_lo;

  gf_sub_mul #(.SUB_W(SUB_W), .SUB_POLY(SUB_POLY)) u_cross (.x(sum_a), .y(sum_b), .p(t_cross));
  gf_sub_mul #(.SUB_W(SUB_W), .SUB_POLY(SUB_POLY)) u_low   (.x(a_lo),  .y(b_lo),  .p(t_low));
  gf_sub_mul #(.SUB_W(SUB_W), .SUB_POLY(SUB_POLY)) u_high  (.x(a_hi),  .y(b_hi),  .p(t_high));
  gf_sub_mul #(.SUB_W(SUB_W), .SUB_POLY(SUB_POLY)) u_fold  (.x(t_high), .y(EXT_K), .p(t_high_k));

  assign hi_out = t_cross ^ t_low;
  assign lo_out = t_high_k ^ t_low;
  assign p = {hi_out, lo_out};

  always_comb begin
    // R1
    if (a_hi == '0 && b_hi == '0) begin
      sub_only_chk: assert (hi_out == '0 && lo_out == t_cross);
    end
  end
endmodule

// File: rtl/gf4096_tower_mul.sv
module gf4096_tower_mul
  import gf_tower_pkg::*;
#(
  parameter int    OUT_REG = 1,
  parameter int    SUB_W   = GFT_SUB_W,
  parameter logic [SUB_W:0]     SUB_POLY = GFT_SUB_POLY,
  parameter logic [SUB_W-1:0]   EXT_K    = GFT_EXT_K,
  parameter logic [2*SUB_W-1:0] STEP_K   = GFT_STEP_K,
  localparam int   EL_W    = 2 * SUB_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic            step_mode,
  input  logic [EL_W-1:0] op_a,
  input  logic [EL_W-1:0] op_b,
  output logic            out_valid,
  output logic [EL_W-1:0] product
);
  logic [EL_W-1:0] b_eff;
  logic [EL_W-1:0] core_p;
  logic            step_zero;
  logic [EL_W-1:0] result;

  assign b_eff     = step_mode ? STEP_K : op_b;
  assign step_zero = step_mode && (op_a == '0);

  gf_tower_core #(.SUB_W(SUB_W), .SUB_POLY(SUB_POLY), .EXT_K(EXT_K)) u_core (
    .a(op_a), .b(b_eff), .p(core_p)
  );

  assign result = step_zero ? EL_W'(1) : core_p;

  generate
    if (OUT_REG != 0) begin : g_reg
      logic            v_q;
      logic [EL_W-1:0] p_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          v_q <= 1'b0;
          p_q <= '0;
        end else begin
          v_q <= in_valid;
          if (in_valid) p_q <= result;
        end
      end
      assign out_valid = v_q;
      assign product   = p_q;

      // R8
      valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
      // R9
      hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(product)));
      // R7
      step_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && step_mode && op_a == '0) |=> (product == EL_W'(1)));
      // R5
      zero_operand_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !step_mode && (op_a == '0 || op_b == '0)) |=> (product == '0));
      // R3
      identity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !step_mode && op_b == EL_W'(1)) |=> (product == $past(op_a)));
    end else begin : g_comb
      assign out_valid = in_valid;
      assign product   = result;
    end
  endgenerate
endmodule

// File: tb/gf4096_tower_mul_bench.sv
module gf4096_tower_mul_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        step_mode = 1'b0;
  logic [11:0] op_a = '0;
  logic [11:0] op_b = '0;
  logic        out_valid;
  logic [11:0] product;
  int total = 0;
  int fails = 0;

  always #10 clk = ~clk;

  gf4096_tower_mul u_gf4096_tower_mul (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .step_mode(step_mode),
    .op_a(op_a), .op_b(op_b), .out_valid(out_valid), .product(product)
  );

  // carry-less product, then reduction from the top bit down
  function automatic logic [5:0] ref64(input logic [5:0] u, input logic [5:0] v);
    logic [10:0] w;
    w = '0;
    for (int i = 0; i < 6; i++) if (v[i]) w = w ^ (11'(u) << i);
    for (int j = 10; j >= 6; j--) if (w[j]) w = w ^ (11'h043 << (j - 6));
    return w[5:0];
  endfunction

  // (ah X + al)(bh X + bl) with X^2 = X + 0x21
  function automatic logic [11:0] ref12(input logic [11:0] u, input logic [11:0] v);
    logic [5:0] hh, hl, lh, ll;
    hh = ref64(u[11:6], v[11:6]);
    hl = ref64(u[11:6], v[5:0]);
    lh = ref64(u[5:0], v[11:6]);
    ll = ref64(u[5:0], v[5:0]);
    return {hh ^ hl ^ lh, ref64(hh, 6'h21) ^ ll};
  endfunction

  task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%03h expected=%03h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [11:0] a, input logic [11:0] b, input logic m,
                       output logic [11:0] res);
    @(negedge clk);
    in_valid = 1'b1; op_a = a; op_b = b; step_mode = m;
    @(negedge clk);
    in_valid = 1'b0;
    res = product;
  endtask

  task automatic t_reset();
    check("R10 out_valid", {11'b0, out_valid}, 12'h000);
    check("R10 product", product, 12'h000);
  endtask

  task automatic t_subfield();
    logic [11:0] r;
    apply(12'h020, 12'h002, 1'b0, r); check("R1 x^5*x", r, 12'h003);
    apply(12'h03F, 12'h03F, 1'b0, r); check("R1 low only", r, {6'h0, ref64(6'h3F, 6'h3F)});
  endtask

  task automatic t_identity_zero();
    logic [11:0] r;
    apply(12'hABC, 12'h001, 1'b0, r); check("R3 a*1", r, 12'hABC);
    apply(12'h001, 12'h5E7, 1'b0, r); check("R3 1*b", r, 12'h5E7);
    apply(12'h000, 12'h9D3, 1'b0, r); check("R5 0*b", r, 12'h000);
    apply(12'h7A1, 12'h000, 1'b0, r); check("R5 a*0", r, 12'h000);
  endtask

  task automatic t_random();
    logic [11:0] r1, r2, a, b;
    for (int k = 0; k < 150; k++) begin
      a = 12'($urandom); b = 12'($urandom);
      apply(a, b, 1'b0, r1); check("R2 random", r1, ref12(a, b));
      apply(b, a, 1'b0, r2); check("R4 commute", r2, r1);
    end
    apply(12'hFFF, 12'hFFF, 1'b0, r1); check("R2 all ones", r1, ref12(12'hFFF, 12'hFFF));
    apply(12'hFC0, 12'h040, 1'b0, r1); check("R2 high only", r1, ref12(12'hFC0, 12'h040));
  endtask

  task automatic t_step();
    logic [11:0] r;
    apply(12'h000, 12'h3C5, 1'b1, r); check("R7 zero step", r, 12'h001);
    apply(12'h001, 12'h777, 1'b1, r); check("R6 one step", r, ref12(12'h001, 12'hE01));
    apply(12'h4D2, 12'h000, 1'b1, r); check("R6 step b=0", r, ref12(12'h4D2, 12'hE01));
    apply(12'h4D2, 12'hFFF, 1'b1, r); check("R6 step b ignored", r, ref12(12'h4D2, 12'hE01));
  endtask

  task automatic t_timing();
    logic [11:0] held;
    @(negedge clk);
    in_valid = 1'b1; op_a = 12'h123; op_b = 12'h456; step_mode = 1'b0;
    #1 check("R8 no early valid", {11'b0, out_valid}, 12'h000);
    @(negedge clk);
    check("R8 valid next cycle", {11'b0, out_valid}, 12'h001);
    check("R8 product", product, ref12(12'h123, 12'h456));
    in_valid = 1'b0;
    held = product;
    for (int k = 0; k < 3; k++) begin
      op_a = 12'($urandom); op_b = 12'($urandom);
      @(negedge clk);
      check("R9 valid low", {11'b0, out_valid}, 12'h000);
      check("R9 product held", product, held);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_subfield();
    t_identity_zero();
    t_random();
    t_step();
    t_timing();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule